// File: doc/BRIEF.md
# Glitch-free clock source switch

This block drives a single output clock from one of up to four input clocks, picked by a small binary select. It is meant to sit in front of a clock tree whose source must be changed while the chip is running. For example, it can move logic from a slow reference clock to a fast generated clock once the faster clock has locked.

A mode parameter picks one of two variants. In the plain variant the output is a combinational multiplexer of the inputs, and it can glitch at the moment the select changes. In the glitch-free variant every input has its own branch with an enable that is synchronised into that input's clock domain. A branch turns its enable off only on its own falling edge. A branch turns its enable on only after it has seen every other enable off. As a result, the output stays low through the handover and then restarts on a full pulse of the new clock.

The glitch-free handover needs the clock being left to keep toggling. If that clock has stopped, the output stays where it is. Reset is synchronous and active low. While reset is held, input 0 drives the output whatever the select says, so input 0 must be running for the block to leave its initial state.

Top module: `clk_switch`

## Requirements
- R1: The select value picks input 0 for 0, input 1 for 1, input 2 for 2 and input 3 for 3. In the plain mode the output follows the picked input with no register in the path.
- R2: In the plain mode, a select value that names an input beyond the configured number of inputs gives a constant low output.
- R3: In the glitch-free mode, while reset is low and after one falling edge of every input, the output follows input 0 whatever the select holds. After reset is released with select 0, the output keeps following input 0.
- R4: In the glitch-free mode, the output never shows a high or low pulse shorter than half the period of the faster of the two clocks involved in a switch.
- R5: In the glitch-free mode, at most one input branch drives the output at any time. The output therefore never carries a mix of two inputs.
- R6: In the glitch-free mode, after a select change with both clocks running, the output follows the newly picked input within four periods of the slower of the old and new clocks.
- R7: In the glitch-free mode, if the currently selected clock is stopped low, a select change leaves the output low. Once that clock toggles again, the switch completes as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | NUM_CLKS | Candidate source clocks, bit i is input i |
| rst_n | input | 1 | Synchronous active-low reset, sampled in each input's domain |
| src_sel | input | SEL_W | Binary index of the wanted source |
| clk_out | output | 1 | Selected clock |

## Verification
The plain path has no register, so its output is due a few time units after the select changes. The bench samples it one step after each change, always between clock edges.

The glitch-free handover takes up to one and a half periods of the old clock to drop the old enable. It then takes up to one and a half periods of the new clock to raise the new one. The bench therefore waits four periods of the slower clock before it compares the output against the new source at thirty points between edges.

Reset acts at the first falling edge of each input, so the bench holds reset across several periods of the slowest input before it checks the output. A monitor timestamps every output edge and counts any pulse shorter than half the fastest period, and that count is checked after every switch.

// File: rtl/clksw_pkg.sv
// Shared definitions for the clock source switch.
// Assumes: nothing beyond IEEE 1800-2017.
package clksw_pkg;

    // Upper bound on the number of source clocks.
    localparam int MAX_CLKS = 4;

    // Switch variant: plain combinational mux or handshake with clean handover.
    typedef enum logic {
        SW_PLAIN      = 1'b0,
        SW_GLITCHFREE = 1'b1
    } sw_mode_e;

endpackage

// File: rtl/clksw_sync.sv
// Two-flop request synchroniser for one source branch.
// The first stage samples on the rising edge and the second updates on the
// falling edge, so the output changes only while the branch clock is low.
// Assumes: rst_n is held low across at least one falling edge of clk.
module clksw_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic meta_q;

    // Stage 1: capture the asynchronous request on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) meta_q <= RST_VAL;
        else        meta_q <= d;
    end

    // Stage 2: move the enable on the falling edge, during the low phase.
    always_ff @(negedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= meta_q;
    end

endmodule

// File: rtl/clksw_branch.sv
// One source branch of the glitch-free switch.
// The branch requests its enable when it is selected and every other branch
// is off, synchronises that request into its own clock, and gates its clock
// with the result.
// Assumes: select is held stable for several periods around a switch.
module clksw_branch #(
    parameter logic RESET_EN = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic sel_hit_i,
    input  logic others_on_i,
    output logic en_o,
    output logic gclk_o
);

    logic req;
    logic rst_low_q;

    // Request: picked by the select and no competing branch enabled.
    always_comb req = sel_hit_i & ~others_on_i;

    clksw_sync #(.RST_VAL(RESET_EN)) u_sync (
        .clk   (clk_i),
        .rst_n (rst_n),
        .d     (req),
        .q     (en_o)
    );

    // Gate: the enable changes only while clk_i is low, so no partial pulse.
    always_comb gclk_o = clk_i & en_o;

    // Remember whether reset was seen at the last falling edge (checker aid).
    always_ff @(negedge clk_i) rst_low_q <= !rst_n;

    // Reset loads the branch's reset enable value.
    always @(posedge clk_i) if (rst_low_q === 1'b1) AST_RESET_STATE: assert (en_o == RESET_EN); // R3

    // A branch only comes on while the select still names it.
    AST_EN_NEEDS_SEL: assert property (@(negedge clk_i) disable iff (!rst_n) $rose(en_o) |-> sel_hit_i); // R1

    // A branch only comes on while every other branch is off.
    AST_EN_ALONE: assert property (@(negedge clk_i) disable iff (!rst_n) $rose(en_o) |-> !others_on_i); // R5

endmodule

// File: rtl/clk_switch.sv
// Clock source switch, top level.
// MODE = SW_PLAIN gives a combinational mux. MODE = SW_GLITCHFREE builds
// one synchronised branch per input with a break-before-make handover.
// Assumes: NUM_CLKS <= MAX_CLKS and NUM_CLKS <= 2**SEL_W. The clock being
// left must keep toggling for a glitch-free switch to finish.
module clk_switch
    import clksw_pkg::*;
#(
    parameter int       NUM_CLKS = 4,
    parameter int       SEL_W    = 2,
    parameter sw_mode_e MODE     = SW_PLAIN
) (
    input  logic [NUM_CLKS-1:0] clk_in,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    src_sel,
    output logic                clk_out
);

    localparam int LAST_IDX = NUM_CLKS - 1;

    if (MODE == SW_GLITCHFREE) begin : g_glitchfree

        logic [NUM_CLKS-1:0] en_vec;
        logic [NUM_CLKS-1:0] gclk_vec;

        for (genvar g = 0; g <= LAST_IDX; g++) begin : g_branch
            logic hit;
            logic others;

            // Decode: this branch is the one the select names.
            always_comb hit = (src_sel == SEL_W'(g));

            // Competition: any other branch currently enabled.
            always_comb others = |(en_vec & ~(NUM_CLKS'(1) << g));

            clksw_branch #(.RESET_EN((g == 0) ? 1'b1 : 1'b0)) u_branch (
                .clk_i       (clk_in[g]),
                .rst_n       (rst_n),
                .sel_hit_i   (hit),
                .others_on_i (others),
                .en_o        (en_vec[g]),
                .gclk_o      (gclk_vec[g])
            );
        end

        // Merge: at most one gated clock is live, so an OR is enough.
        always_comb clk_out = |gclk_vec;

        // Exclusivity of the branch enables across domains.
        always_comb if (rst_n && !$isunknown(en_vec)) AST_ONE_SOURCE: assert ($onehot0(en_vec)); // R5

    end else begin : g_plain

        // Mux: pass the input named by the select, low if it does not exist.
        always_comb begin
            clk_out = 1'b0;
            for (int i = 0; i <= LAST_IDX; i++) begin
                if (src_sel == SEL_W'(i)) clk_out = clk_in[i];
            end
        end

        // An absent input never reaches the output.
        always_comb if (rst_n && !$isunknown(src_sel) && (int'(src_sel) >= NUM_CLKS)) AST_ABSENT_QUIET: assert (!clk_out); // R2

    end

endmodule

// File: tb/sim_clk_switch.sv
// Bench for clk_switch: u0 is the glitch-free variant with four inputs,
// u1 the plain variant with three inputs.
module sim_clk_switch;
    import clksw_pkg::*;

    localparam int CLK_PERIOD = 100;
    localparam int HALF[4]    = '{CLK_PERIOD/2, 70, 30, 110};
    localparam int MIN_PULSE  = 30;
    localparam int SAMPLES    = 30;
    localparam int WATCHDOG   = 200000;

    // Table: {select[2:1], live_in_u1[0]}, walked in order.
    localparam int NVEC = 8;
    localparam logic [2:0] VEC [NVEC] = '{
        {2'd1, 1'b1}, {2'd2, 1'b1}, {2'd3, 1'b0}, {2'd0, 1'b1},
        {2'd2, 1'b1}, {2'd1, 1'b1}, {2'd3, 1'b0}, {2'd0, 1'b1}
    };

    logic [3:0] clk_in;
    logic [3:0] run;
    logic       rst_n;
    logic [1:0] sel0;
    logic [1:0] sel1;
    logic       clk_out0;
    logic       clk_out1;

    int checks = 0;
    int errors = 0;
    int glitch_cnt = 0;
    bit mon_on = 0;
    longint last_t = -1;

    for (genvar g = 0; g < 4; g++) begin : g_clk
        logic c = 1'b0;
        initial forever begin
            #(HALF[g]);
            if (run[g] || c) c = ~c;
        end
        assign clk_in[g] = c;
    end

    clk_switch #(.NUM_CLKS(4), .SEL_W(2), .MODE(SW_GLITCHFREE)) u0 (
        .clk_in (clk_in), .rst_n (rst_n), .src_sel (sel0), .clk_out (clk_out0)
    );

    clk_switch #(.NUM_CLKS(3), .SEL_W(2), .MODE(SW_PLAIN)) u1 (
        .clk_in (clk_in[2:0]), .rst_n (rst_n), .src_sel (sel1), .clk_out (clk_out1)
    );

    // Pulse-width monitor on the glitch-free output.
    always @(clk_out0) begin
        if (mon_on) begin
            if (last_t >= 0 && ($time - last_t) < MIN_PULSE) glitch_cnt++;
            last_t = $time;
        end
    end

    function automatic int period(input int idx);
        return 2 * HALF[idx];
    endfunction

    // Compare one output against a source (or constant low) at SAMPLES points between edges.
    task automatic follow(input int which, input int src, input bit live, input string req);
        int bad = 0;
        logic act = 1'b0;
        logic exp = 1'b0;
        logic a, e;
        for (int k = 0; k < SAMPLES; k++) begin
            #10;
            a = (which == 0) ? clk_out0 : clk_out1;
            e = live ? clk_in[src] : 1'b0;
            if (a !== e) begin
                if (bad == 0) begin act = a; exp = e; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: u%0d source %0d, %0d mismatches, actual %b expected %b",
                     req, which, src, bad, act, exp);
        end
    endtask

    task automatic glitch_check(input string req);
        checks++;
        if (glitch_cnt != 0) begin
            errors++;
            $display("FAIL %s: short pulses actual %0d expected 0", req, glitch_cnt);
        end
    endtask

    initial begin
        #(WATCHDOG);
        errors++;
        $display("FAIL watchdog: run still active at %0t, expected finished", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int prev;
        run = 4'hF;
        rst_n = 1'b0;
        sel0 = 2'd0;
        sel1 = 2'd0;
        #5;

        // R3: reset state, input 0 drives the output.
        #(3 * period(3));
        follow(0, 0, 1'b1, "R3 during reset");
        rst_n = 1'b1;
        #(period(3));
        follow(0, 0, 1'b1, "R3 after reset");
        mon_on = 1;
        last_t = -1;

        // Table walk: plain mux immediately, glitch-free after settling.
        prev = 0;
        for (int v = 0; v < NVEC; v++) begin
            int s;
            int wait_t;
            s = int'(VEC[v][2:1]);
            sel0 = VEC[v][2:1];
            sel1 = VEC[v][2:1];
            follow(1, s, VEC[v][0], VEC[v][0] ? "R1 plain mux" : "R2 plain absent input");
            wait_t = 4 * ((period(prev) > period(s)) ? period(prev) : period(s));
            #(wait_t);
            follow(0, s, 1'b1, "R6 switch latency");
            glitch_check("R4 R5 clean handover");
            prev = s;
        end

        // R3: reset mid-run with select 3 forces input 0.
        sel0 = 2'd3;
        #(4 * period(3));
        mon_on = 0;
        rst_n = 1'b0;
        #(3 * period(3));
        follow(0, 0, 1'b1, "R3 reset overrides select");
        rst_n = 1'b1;
        #(4 * period(3));
        follow(0, 3, 1'b1, "R6 switch after reset release");

        // R7: old clock stopped, the output stays parked low.
        sel0 = 2'd0;
        #(4 * period(3));
        follow(0, 0, 1'b1, "R6 back to input 0");
        mon_on = 1;
        last_t = -1;
        run[0] = 1'b0;
        #(2 * CLK_PERIOD);
        sel0 = 2'd2;
        #(20 * CLK_PERIOD);
        follow(0, 0, 1'b0, "R7 parked while old clock stopped");
        run[0] = 1'b1;
        #(4 * CLK_PERIOD);
        follow(0, 2, 1'b1, "R7 completes after restart");
        glitch_check("R4 clean restart");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule